// File: doc/BRIEF.md
# Shift-Add RGB to Grayscale Pipeline

This block turns a stream of 24-bit colour pixels into a stream of 8-bit grey levels. It uses no multipliers. Each channel byte is weighted by a sum of fixed right shifts of itself: red near 0.299, green near 0.587 and blue near 0.114. The three weighted values are then added in a registered adder tree. Every shifted copy keeps its fractional bits (FRAC_W of them) until the final stage, where the sum is truncated to an integer and clamped to 255. Because every weight sits just below its ideal value, the result equals the exactly weighted grey level or is one count below it.

A pixel is offered with `in_valid` high and is taken on that clock edge; no back-pressure exists. The result appears three rising edges later with `out_valid` high for one cycle. A new pixel may enter on every clock. Between results, `out_gray` keeps the last value it produced.

The reset input is asynchronous and active low. Its release is synchronised internally over two clock edges.

Top module: `rgb_gray_pipe`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_gray` is 0.
- R2: A pixel sampled on a rising edge with `in_valid` high makes `out_valid` high for exactly one cycle after the third following rising edge; `out_valid` is never high otherwise.
- R3: The result equals floor((608·R + 1202·G + 233·B) / 2048). These weights are the shift sets R{2,5,6}, G{1,4,6,7,10} and B{4,5,6,8,11}, where each shift k contributes channel/2^k.
- R4: The result is floor(0.299·R + 0.587·G + 0.114·B), or one less than that value.
- R5: The corner pixels give fixed results: (0,0,0)→0, (255,255,255)→254, (255,0,0)→75, (0,255,0)→149, (0,0,255)→29.
- R6: Cycles with `in_valid` low produce no result, whatever data is on the colour inputs, and `out_gray` holds its last result while `out_valid` is low.
- R7: Pixels offered on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present on the colour inputs |
| in_r | input | 8 | Red byte |
| in_g | input | 8 | Green byte |
| in_b | input | 8 | Blue byte |
| out_valid | output | 1 | Result present on out_gray |
| out_gray | output | 8 | Grey level |

## Verification
Random pixels separate a correct shift set from one with a dropped or wrong term, because the result is compared exactly against the 608/1202/233 weighting and against the ideal weighting with a tolerance of minus one.

The all-zero, all-white and single-saturated-channel pixels test each channel's full-scale weight on its own. The white pixel also tests the total of the three weights.

Random gaps in `in_valid`, with junk on the colour inputs during the gaps, check that bubbles are skipped and that the output holds between results. Long unbroken bursts check the one-per-clock ordering and the fixed three-edge latency.

// File: rtl/gray_pkg.sv
package gray_pkg;
  // Width of one colour channel.
  localparam int CH_W = 8;
  // Width of one shift-amount field in the shift-set parameters.
  localparam int SH_W = 4;
  typedef logic [CH_W-1:0] chan_t;
endpackage

// File: rtl/gray_rst_sync.sv
module gray_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/gray_stage_reg.sv
module gray_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/gray_chan_weight.sv
module gray_chan_weight #(
  parameter int CH_W    = 8,
  parameter int FRAC_W  = 11,
  parameter int ACC_W   = 20,
  parameter int SH_W    = 4,
  parameter int N_TERMS = 3,
  parameter logic [N_TERMS*SH_W-1:0] SHIFTS = 12'h652
) (
  input  logic [CH_W-1:0]  chan,
  output logic [ACC_W-1:0] weighted
);
  localparam int EXT_W = CH_W + FRAC_W;

  // The channel as fixed point, with FRAC_W fractional bits below it.
  logic [EXT_W-1:0] ext;
  assign ext = {chan, {FRAC_W{1'b0}}};

  // Running sums of the shifted copies, one slot per term.
  logic [ACC_W-1:0] part [N_TERMS+1];
  assign part[0] = '0;

  for (genvar i = 0; i < N_TERMS; i++) begin : g_term
    localparam int K = int'(SHIFTS[i*SH_W +: SH_W]);
    logic [ACC_W-1:0] term;
    assign term        = ACC_W'(ext >> K);
    assign part[i + 1] = part[i] + term;
  end

  assign weighted = part[N_TERMS];
endmodule

// File: rtl/rgb_gray_pipe.sv
module rgb_gray_pipe #(
  parameter int FRAC_W = 11,
  parameter int N_R    = 3,
  parameter logic [N_R*4-1:0] R_SHIFTS = 12'h652,
  parameter int N_G    = 5,
  parameter logic [N_G*4-1:0] G_SHIFTS = 20'hA7641,
  parameter int N_B    = 5,
  parameter logic [N_B*4-1:0] B_SHIFTS = 20'hB8654
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_r,
  input  logic [7:0] in_g,
  input  logic [7:0] in_b,
  output logic       out_valid,
  output logic [7:0] out_gray
);
  import gray_pkg::*;

  localparam int ACC_W = CH_W + FRAC_W + 1;
  localparam int INT_W = ACC_W - FRAC_W;
  localparam int LAT   = 3;

  logic rst_i_n;

  gray_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // Valid line: one bit per pipeline stage.
  logic [LAT-1:0] vld_q;
  logic [LAT-1:0] vld_nxt;

  always_comb begin
    vld_nxt = {vld_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) vld_q <= '0;
    else          vld_q <= vld_nxt;
  end

  // Stage 1: one weighted value per channel.
  logic [ACC_W-1:0] w_r, w_g, w_b;
  logic [ACC_W-1:0] s1_r, s1_g, s1_b;

  gray_chan_weight #(.CH_W(CH_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .SH_W(SH_W),
                     .N_TERMS(N_R), .SHIFTS(R_SHIFTS))
    u_wr (.chan(in_r), .weighted(w_r));
  gray_chan_weight #(.CH_W(CH_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .SH_W(SH_W),
                     .N_TERMS(N_G), .SHIFTS(G_SHIFTS))
    u_wg (.chan(in_g), .weighted(w_g));
  gray_chan_weight #(.CH_W(CH_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .SH_W(SH_W),
                     .N_TERMS(N_B), .SHIFTS(B_SHIFTS))
    u_wb (.chan(in_b), .weighted(w_b));

  gray_stage_reg #(.W(ACC_W)) u_s1r (.clk(clk), .rst_n(rst_i_n), .en(in_valid), .d(w_r), .q(s1_r));
  gray_stage_reg #(.W(ACC_W)) u_s1g (.clk(clk), .rst_n(rst_i_n), .en(in_valid), .d(w_g), .q(s1_g));
  gray_stage_reg #(.W(ACC_W)) u_s1b (.clk(clk), .rst_n(rst_i_n), .en(in_valid), .d(w_b), .q(s1_b));

  // Stage 2: red plus green; blue waits one stage.
  logic [ACC_W-1:0] rg_sum, s2_rg, s2_b;
  assign rg_sum = s1_r + s1_g;

  gray_stage_reg #(.W(ACC_W)) u_s2rg (.clk(clk), .rst_n(rst_i_n), .en(vld_q[0]), .d(rg_sum), .q(s2_rg));
  gray_stage_reg #(.W(ACC_W)) u_s2b  (.clk(clk), .rst_n(rst_i_n), .en(vld_q[0]), .d(s1_b),   .q(s2_b));

  // Stage 3: final add, drop the fraction, clamp to full scale.
  logic [ACC_W-1:0] total;
  logic [INT_W-1:0] whole;
  chan_t            clamped;

  assign total = s2_rg + s2_b;
  assign whole = total[ACC_W-1:FRAC_W];

  always_comb begin
    if (whole > INT_W'({CH_W{1'b1}})) clamped = '1;
    else                              clamped = whole[CH_W-1:0];
  end

  gray_stage_reg #(.W(CH_W)) u_s3 (.clk(clk), .rst_n(rst_i_n), .en(vld_q[1]), .d(clamped), .q(out_gray));

  assign out_valid = vld_q[LAT-1];
endmodule

// File: rtl/gray_pipe_chk.sv
module gray_pipe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_r,
  input logic [7:0] in_g,
  input logic [7:0] in_b,
  input logic       out_valid,
  input logic [7:0] out_gray
);
  always @(posedge clk) begin
    if (!rst_n) begin
      // R1
      rst_idle_chk: assert (!out_valid && out_gray == 8'd0);
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_gray));

  // R5
  black_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_r, 3) == 8'd0 && $past(in_g, 3) == 8'd0 && $past(in_b, 3) == 8'd0)
      |-> out_gray == 8'd0);

  // R5
  white_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_r, 3) == 8'hFF && $past(in_g, 3) == 8'hFF && $past(in_b, 3) == 8'hFF)
      |-> out_gray >= 8'd254);
endmodule

bind rgb_gray_pipe gray_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_r(in_r), .in_g(in_g),
  .in_b(in_b), .out_valid(out_valid), .out_gray(out_gray)
);

// File: tb/tb_rgb_gray_pipe.sv
`timescale 1ns/1ps
module tb_rgb_gray_pipe;
  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_r, in_g, in_b;
  logic       out_valid;
  logic [7:0] out_gray;

  int checks;
  int failures;
  bit done;
  bit mon_en;

  rgb_gray_pipe dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_r(in_r), .in_g(in_g),
    .in_b(in_b), .out_valid(out_valid), .out_gray(out_gray)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Result from the stated shift weights (R3).
  function automatic int ref_shift(int r, int g, int b);
    return (608 * r + 1202 * g + 233 * b) / 2048;
  endfunction

  // Ideal weighted grey level, truncated (R4).
  function automatic int ref_exact(int r, int g, int b);
    return (299 * r + 587 * g + 114 * b) / 1000;
  endfunction

  // Bench model of the three-edge delay: what must emerge (R2).
  logic       m_v [3];
  logic [7:0] m_r [3];
  logic [7:0] m_g [3];
  logic [7:0] m_b [3];
  int         exp_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_v[i] <= 1'b0; m_r[i] <= '0; m_g[i] <= '0; m_b[i] <= '0;
      end
    end else begin
      m_v[0] <= in_valid; m_r[0] <= in_r; m_g[0] <= in_g; m_b[0] <= in_b;
      for (int i = 1; i < 3; i++) begin
        m_v[i] <= m_v[i-1]; m_r[i] <= m_r[i-1]; m_g[i] <= m_g[i-1]; m_b[i] <= m_b[i-1];
      end
    end
  end

  // Per-cycle monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (mon_en) begin
      checks++;
      if (out_valid !== m_v[2]) begin
        failures++;
        $display("FAIL R2/R7 out_valid actual=%0b expected=%0b", out_valid, m_v[2]);
      end
      if (m_v[2]) begin
        int e_s, e_x;
        e_s = ref_shift(m_r[2], m_g[2], m_b[2]);
        e_x = ref_exact(m_r[2], m_g[2], m_b[2]);
        exp_hold = e_s;
        checks++;
        if (int'(out_gray) != e_s) begin
          failures++;
          $display("FAIL R3 gray for (%0d,%0d,%0d) actual=%0d expected=%0d",
                   m_r[2], m_g[2], m_b[2], out_gray, e_s);
        end
        checks++;
        if (int'(out_gray) > e_x || int'(out_gray) + 1 < e_x) begin
          failures++;
          $display("FAIL R4 gray for (%0d,%0d,%0d) actual=%0d expected=%0d or %0d",
                   m_r[2], m_g[2], m_b[2], out_gray, e_x, e_x - 1);
        end
      end else begin
        checks++;
        if (int'(out_gray) != exp_hold) begin
          failures++;
          $display("FAIL R6 held gray actual=%0d expected=%0d", out_gray, exp_hold);
        end
      end
    end
  end

  task automatic idle();
    in_valid = 1'b0;
    in_r = 8'($urandom); in_g = 8'($urandom); in_b = 8'($urandom);
  endtask

  // Drive one pixel alone and check its result at the output (R5).
  task automatic corner(input logic [7:0] r, g, b, input int want);
    @(negedge clk);
    in_valid = 1'b1; in_r = r; in_g = g; in_b = b;
    @(posedge clk);
    @(negedge clk);
    idle();
    @(posedge clk);
    @(posedge clk);
    #1;
    checks++;
    if (!out_valid || int'(out_gray) != want) begin
      failures++;
      $display("FAIL R5 corner (%0d,%0d,%0d) actual=%0b/%0d expected=1/%0d",
               r, g, b, out_valid, out_gray, want);
    end
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0; mon_en = 1'b0; exp_hold = 0;
    void'($urandom(32'h1ACE_5EED));
    rst_n = 1'b0;
    in_valid = 1'b0; in_r = '0; in_g = '0; in_b = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_gray !== 8'd0) begin
      failures++;
      $display("FAIL R1 reset actual=%0b/%0d expected=0/0", out_valid, out_gray);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_en = 1'b1;

    // R5 directed corner pixels
    corner(8'd0,   8'd0,   8'd0,   0);
    corner(8'd255, 8'd255, 8'd255, 254);
    corner(8'd255, 8'd0,   8'd0,   75);
    corner(8'd0,   8'd255, 8'd0,   149);
    corner(8'd0,   8'd0,   8'd255, 29);

    // R7: unbroken burst
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_r = 8'($urandom); in_g = 8'($urandom); in_b = 8'($urandom);
    end
    // R6: junk on the colour inputs with in_valid low
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      idle();
    end
    // Random mix with gaps
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom_range(3, 0) != 0) begin
        in_valid = 1'b1;
        in_r = 8'($urandom); in_g = 8'($urandom); in_b = 8'($urandom);
      end else begin
        idle();
      end
    end
    @(negedge clk);
    idle();
    repeat (6) @(negedge clk);
    mon_en = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule